// File: doc/BRIEF.md
# Receive Frame Error and Length Checker

This block sits on the receive side of a bit-oriented, flag-delimited link. It comes after the stage that finds flag sequences and removes stuffed zeros, and before the logic that writes frame bytes into memory. It collects the destuffed data bits of each frame into bytes, least significant bit first, and forwards them on a byte-valid strobe. It also counts the bytes of the frame.

When a frame closes, the block emits a one-cycle end pulse together with a status word. The status word holds the received length in whole bytes and three error flags: over-length, non-octet-aligned and aborted.

A static maximum-length input limits how many bytes of a frame are forwarded. Bytes past the limit are dropped, but they are still counted. The reported length is therefore the true byte count, and the over-length condition appears only when the closing flag arrives. An abort indication ends the frame at once. The block then ignores bits until the next flag.

Top module: `rxf_err_len_chk`

## Requirements
- R1: While rst_n is low, and in the first cycle after it goes high, out_byte_vld, out_end, out_len and all three error flags are 0.
- R2: Inside a frame, every BYTE_W accepted bits form one byte. The first bit received lands in bit 0. out_byte_vld pulses for one cycle in the cycle after the edge that took the last bit, with the byte on out_byte.
- R3: Before the first flag, and after an abort until the next flag, in_bit_vld bits are ignored: they produce no byte, no end pulse and no count.
- R4: A flag that arrives while a frame holds at least one data bit closes that frame. out_end pulses for one cycle after that edge, and out_len equals the number of whole bytes received. The same flag also opens the next frame, with its counters cleared.
- R5: A flag that arrives while the open frame holds no data bits produces no end pulse, so back-to-back flags create no frame.
- R6: The byte with zero-based index k is forwarded only when k < max_len. At a flag close, out_err_lg is 1 exactly when the byte count exceeds max_len, and out_len still reports the full count.
- R7: At a flag close, out_err_no is 1 exactly when the bit count is not a multiple of BYTE_W. The residual bits are dropped and are not counted in out_len.
- R8: An in_abort pulse while a frame holds data produces an end pulse with out_err_ab=1, out_err_lg=0 and out_err_no=0, and with out_len equal to the whole bytes received so far.
- R9: The byte count saturates at 2^LEN_W-1 and does not wrap.
- R10: out_len and the error flags change only in a cycle with out_end=1. out_end and out_byte_vld are never high in the same cycle.
- R11: When the inputs arrive together in one cycle, in_abort has priority over in_flag, and in_flag has priority over in_bit_vld. The lower-priority bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_len | input | LEN_W | Largest number of bytes forwarded per frame |
| in_bit_vld | input | 1 | Destuffed data bit present |
| in_bit | input | 1 | Destuffed data bit |
| in_flag | input | 1 | Flag sequence completed this cycle |
| in_abort | input | 1 | Run of seven or more ones seen this cycle |
| out_byte_vld | output | 1 | Byte strobe |
| out_byte | output | BYTE_W | Assembled byte |
| out_end | output | 1 | Frame closed, status valid |
| out_len | output | LEN_W | Whole bytes received in the closed frame |
| out_err_lg | output | 1 | Frame exceeded max_len |
| out_err_no | output | 1 | Frame not a whole number of bytes |
| out_err_ab | output | 1 | Frame ended by abort |

## Verification
A wrong bit index shows up within one byte time: out_byte is misaligned, or the strobe lands a cycle early or late. A wrong byte count, or a wrong in-frame state, stays hidden until the frame's end pulse. At that point it appears as a wrong out_len, a wrong over-length flag, a missing end pulse or an extra one. For this reason every frame in the bench is closed and its full status is compared. Over-length frames are mixed with frames at the exact limit, so that a truncation error at the boundary shows as an extra strobe or a missing one.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef struct packed {
      logic lg;
      logic no;
      logic ab;
   } rxf_err_t;

   localparam rxf_err_t RXF_ERR_NONE = '{lg: 1'b0, no: 1'b0, ab: 1'b0};
endpackage

// File: rtl/rxf_bit_asm.sv
module rxf_bit_asm #(
   parameter int BYTE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      shift_en,
   input  logic                      din,
   output logic                      byte_done,
   output logic [BYTE_W-1:0]         byte_nxt,
   output logic [$clog2(BYTE_W)-1:0] bit_idx
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] sr_q;

   assign byte_nxt  = {din, sr_q[BYTE_W-1:1]};
   assign byte_done = shift_en && (bit_idx == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q    <= '0;
         bit_idx <= '0;
      end else if (clr) begin
         bit_idx <= '0;
      end else if (shift_en) begin
         sr_q    <= byte_nxt;
         bit_idx <= (bit_idx == LAST) ? '0 : bit_idx + 1'b1;
      end
   end
endmodule

// File: rtl/rxf_len_ctr.sv
module rxf_len_ctr #(
   parameter int LEN_W  = 16,
   parameter bit SAT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [LEN_W-1:0] cnt
);
   generate
      if (SAT_EN) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n || clr)             cnt <= '0;
            else if (inc && (cnt != '1))   cnt <= cnt + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt <= '0;
            else if (inc)      cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rxf_err_len_chk.sv
module rxf_err_len_chk
   import rxf_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int BYTE_W = 8,
   parameter bit SAT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  max_len,
   input  logic              in_bit_vld,
   input  logic              in_bit,
   input  logic              in_flag,
   input  logic              in_abort,
   output logic              out_byte_vld,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_end,
   output logic [LEN_W-1:0]  out_len,
   output logic              out_err_lg,
   output logic              out_err_no,
   output logic              out_err_ab
);
   localparam int CNT_W = $clog2(BYTE_W);

   generate
      if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte_w
         $error("BYTE_W must be a power of two of at least 2");
      end
      if (LEN_W < 2 || LEN_W > 32) begin : g_bad_len_w
         $error("LEN_W must lie in 2..32");
      end
   endgenerate

   logic              in_frame_q;
   logic              clr;
   logic              shift_en;
   logic              byte_done;
   logic [BYTE_W-1:0] byte_nxt;
   logic [CNT_W-1:0]  bit_idx;
   logic [LEN_W-1:0]  byte_cnt;
   logic              have_data;
   rxf_err_t          err_q;

   assign clr       = in_abort || in_flag;
   assign shift_en  = in_bit_vld && in_frame_q && !clr;
   assign have_data = (byte_cnt != '0) || (bit_idx != '0);

   rxf_bit_asm #(.BYTE_W(BYTE_W)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .shift_en  (shift_en),
      .din       (in_bit),
      .byte_done (byte_done),
      .byte_nxt  (byte_nxt),
      .bit_idx   (bit_idx)
   );

   rxf_len_ctr #(.LEN_W(LEN_W), .SAT_EN(SAT_EN)) u_len (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (shift_en && byte_done),
      .cnt   (byte_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q   <= 1'b0;
         out_byte_vld <= 1'b0;
         out_byte     <= '0;
         out_end      <= 1'b0;
         out_len      <= '0;
         err_q        <= RXF_ERR_NONE;
      end else begin
         out_byte_vld <= 1'b0;
         out_end      <= 1'b0;
         if (in_abort) begin
            if (in_frame_q && have_data) begin
               out_end <= 1'b1;
               out_len <= byte_cnt;
               err_q   <= '{lg: 1'b0, no: 1'b0, ab: 1'b1};
            end
            in_frame_q <= 1'b0;
         end else if (in_flag) begin
            if (in_frame_q && have_data) begin
               out_end <= 1'b1;
               out_len <= byte_cnt;
               err_q   <= '{lg: (byte_cnt > max_len),
                            no: (bit_idx != '0),
                            ab: 1'b0};
            end
            in_frame_q <= 1'b1;
         end else if (shift_en && byte_done) begin
            if (byte_cnt < max_len) begin
               out_byte_vld <= 1'b1;
               out_byte     <= byte_nxt;
            end
         end
      end
   end

   assign out_err_lg = err_q.lg;
   assign out_err_no = err_q.no;
   assign out_err_ab = err_q.ab;
endmodule

// File: rtl/rxf_err_len_chk_sva.sv
module rxf_err_len_chk_sva #(
   parameter int LEN_W  = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LEN_W-1:0]  max_len,
   input logic              in_bit_vld,
   input logic              in_flag,
   input logic              in_abort,
   input logic              out_byte_vld,
   input logic              out_end,
   input logic [LEN_W-1:0]  out_len,
   input logic              out_err_lg,
   input logic              out_err_no,
   input logic              out_err_ab
);
   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_byte_vld && out_end));

   // R4
   end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_end |-> $past(in_flag || in_abort));

   // R11
   byte_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_byte_vld |-> $past(in_bit_vld && !in_flag && !in_abort));

   // R8
   abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_end && out_err_ab) |-> (!out_err_lg && !out_err_no));

   // R5
   end_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_end |=> !out_end);

   // R10
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_end |-> ($stable(out_len) && $stable(out_err_lg) &&
                    $stable(out_err_no) && $stable(out_err_ab)));

   // R6
   over_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_end && out_err_lg) |-> (out_len > $past(max_len)));
endmodule

bind rxf_err_len_chk rxf_err_len_chk_sva #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .max_len      (max_len),
   .in_bit_vld   (in_bit_vld),
   .in_flag      (in_flag),
   .in_abort     (in_abort),
   .out_byte_vld (out_byte_vld),
   .out_end      (out_end),
   .out_len      (out_len),
   .out_err_lg   (out_err_lg),
   .out_err_no   (out_err_no),
   .out_err_ab   (out_err_ab)
);

// File: tb/rxf_err_len_chk_tb.sv
`timescale 1ns/1ps
module rxf_err_len_chk_tb_top;
   localparam int LEN_W  = 8;
   localparam int BYTE_W = 8;
   localparam int SATV   = (1 << LEN_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [LEN_W-1:0]  max_len = '0;
   logic              in_bit_vld = 1'b0;
   logic              in_bit = 1'b0;
   logic              in_flag = 1'b0;
   logic              in_abort = 1'b0;
   logic              out_byte_vld;
   logic [BYTE_W-1:0] out_byte;
   logic              out_end;
   logic [LEN_W-1:0]  out_len;
   logic              out_err_lg;
   logic              out_err_no;
   logic              out_err_ab;

   int n_chk = 0;
   int n_bad = 0;

   // bench-side expected state
   bit              m_in = 0;
   int              m_bytes = 0;
   int              m_bits = 0;
   logic [BYTE_W-1:0] m_sr = '0;
   int              e_len = 0;
   bit              e_lg = 0, e_no = 0, e_ab = 0;

   always #5 clk = ~clk;

   rxf_err_len_chk #(.LEN_W(LEN_W), .BYTE_W(BYTE_W), .SAT_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .max_len(max_len),
      .in_bit_vld(in_bit_vld), .in_bit(in_bit), .in_flag(in_flag), .in_abort(in_abort),
      .out_byte_vld(out_byte_vld), .out_byte(out_byte), .out_end(out_end),
      .out_len(out_len), .out_err_lg(out_err_lg), .out_err_no(out_err_no),
      .out_err_ab(out_err_ab)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int sat_inc(input int v);
      return (v < SATV) ? v + 1 : v;
   endfunction

   // one cycle of stimulus with expected outputs computed from the requirements
   task automatic step(input bit v, input bit b, input bit f, input bit a);
      bit e_bv = 0, e_end = 0;
      logic [BYTE_W-1:0] e_byte = '0;
      @(negedge clk);
      in_bit_vld = v; in_bit = b; in_flag = f; in_abort = a;
      if (a) begin
         if (m_in && (m_bytes != 0 || m_bits != 0)) begin
            e_end = 1; e_len = m_bytes; e_lg = 0; e_no = 0; e_ab = 1;
         end
         m_in = 0; m_bytes = 0; m_bits = 0;
      end else if (f) begin
         if (m_in && (m_bytes != 0 || m_bits != 0)) begin
            e_end = 1; e_len = m_bytes; e_lg = (m_bytes > int'(max_len));
            e_no = (m_bits != 0); e_ab = 0;
         end
         m_in = 1; m_bytes = 0; m_bits = 0;
      end else if (v && m_in) begin
         m_sr = {b, m_sr[BYTE_W-1:1]};
         m_bits++;
         if (m_bits == BYTE_W) begin
            m_bits = 0;
            if (m_bytes < int'(max_len)) begin e_bv = 1; e_byte = m_sr; end
            m_bytes = sat_inc(m_bytes);
         end
      end
      @(posedge clk); #2;
      chk(out_byte_vld == e_bv, "R2/R6 byte strobe", out_byte_vld, e_bv);
      if (e_bv) chk(out_byte == e_byte, "R2 byte value", out_byte, e_byte);
      chk(out_end == e_end, "R4/R5 end pulse", out_end, e_end);
      // R10: status fields hold the last closed frame's values
      chk(out_len == LEN_W'(e_len), "R4/R9 length", out_len, e_len);
      chk(out_err_lg == e_lg, "R6 over-length flag", out_err_lg, e_lg);
      chk(out_err_no == e_no, "R7 alignment flag", out_err_no, e_no);
      chk(out_err_ab == e_ab, "R8 abort flag", out_err_ab, e_ab);
      in_bit_vld = 0; in_flag = 0; in_abort = 0;
   endtask

   task automatic send_byte(input logic [7:0] d);
      for (int i = 0; i < BYTE_W; i++) step(1, d[i], 0, 0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #3000000;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      max_len = 8'd4;
      repeat (3) @(posedge clk);
      #2;
      // R1: outputs cleared while in reset
      chk(out_byte_vld == 0 && out_end == 0, "R1 reset strobes", out_end, 0);
      chk(out_len == 0 && !out_err_lg && !out_err_no && !out_err_ab, "R1 reset status", out_len, 0);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #2;
      chk(out_byte_vld == 0 && out_end == 0 && out_len == 0, "R1 after release", out_len, 0);

      // R3: bits before any flag are ignored
      for (int i = 0; i < 20; i++) step(1, 1'($urandom), 0, 0);
      // R5: back-to-back flags produce no frame
      step(0, 0, 1, 0); step(0, 0, 1, 0); step(0, 0, 1, 0);
      // R2/R4: two-byte frame, closed by a shared flag
      send_byte(8'hA5); send_byte(8'h3C); step(0, 0, 1, 0);
      // R7: non-octet frame with 3 residual bits
      send_byte(8'h81); step(1, 1, 0, 0); step(1, 0, 0, 0); step(1, 1, 0, 0); step(0, 0, 1, 0);
      // R6: exactly at the limit, then one over
      for (int i = 0; i < 4; i++) send_byte(8'(i + 16));
      step(0, 0, 1, 0);
      for (int i = 0; i < 5; i++) send_byte(8'(i + 32));
      step(0, 0, 1, 0);
      // R6: limit of zero forwards nothing
      max_len = 0;
      send_byte(8'h77); step(0, 0, 1, 0);
      max_len = 8'd6;
      // R8: abort mid-frame, then R3: bits ignored until next flag
      send_byte(8'h12); step(1, 1, 0, 0); step(0, 0, 0, 1);
      send_byte(8'hFF); step(0, 0, 1, 0); step(0, 0, 1, 0);
      // R11: abort beats flag, flag beats bit
      send_byte(8'h55); step(1, 1, 1, 1);
      step(0, 0, 1, 0); send_byte(8'h66); step(1, 1, 1, 0); step(0, 0, 1, 0);
      // R9: saturating count with 300 bytes
      max_len = 8'd250;
      step(0, 0, 1, 0);
      for (int i = 0; i < 300; i++) send_byte(8'(i));
      step(0, 0, 1, 0);

      // constrained random frames
      for (int fr = 0; fr < 250; fr++) begin
         int nb = $urandom_range(0, 12);
         int nx = ($urandom_range(0, 3) == 0) ? $urandom_range(1, BYTE_W - 1) : 0;
         max_len = LEN_W'($urandom_range(0, 10));
         for (int i = 0; i < nb; i++) send_byte(8'($urandom));
         for (int i = 0; i < nx; i++) step(1, 1'($urandom), 0, 0);
         if ($urandom_range(0, 9) == 0) begin
            step(0, 0, 0, 1);
            for (int i = 0; i < 5; i++) step(1, 1'($urandom), 0, 0);
         end
         if ($urandom_range(0, 3) == 0) step(0, 0, 0, 0);
         step(0, 0, 1, 0);
      end
      finish_run();
   end
endmodule